// File: doc/BRIEF.md
# Shared-Memory Output-Queued Cell Switch

This block is a four-by-four switch for fixed-size cells. Every cell that enters is stored in one central cell memory that all ports share. The queue for each output port is a hardware FIFO that holds only memory locations, never payload and never next-pointers. Time is divided into cell slots of `CELL_BYTES` cycles, and the block announces each one with `slot_start`. In the first cycle of a slot, any input may raise its start flag and present a destination port. The cell then streams in one byte per cycle.

In the first cycle of the slot, inputs are served in index order, input 0 first. Each accepted cell takes a location from a free-location FIFO. That location is pushed at once into the queue of the destination output, and the cell's bytes are written to it. An input whose cell finds no free location, or finds its destination queue full, loses the cell and increments its own drop counter.

At the end of each slot, every output does two things:
- it returns the location it has just finished sending to the free FIFO;
- it pops the next location from its queue and streams that cell during the following slot.

An output that sees its queue empty at the end of a slot stays idle for the following slot.

Top module: `cell_switch`

## Requirements
- R1: After reset all `out_valid` bits are 0, every drop counter reads 0, and `slot_start` is 1 in the first cycle after reset is released and then in every `CELL_BYTES`-th cycle (53 by default).
- R2: A cell accepted in slot n leaves on its destination output during slot n+1 when that queue was empty. `out_sop` marks the first byte, `out_valid` stays high for exactly `CELL_BYTES` cycles, and the bytes are identical to the input bytes and in the same order.
- R3: Cells from all four inputs aimed at the same output in one slot are all accepted. They leave that output in consecutive slots in input index order, input 0 first.
- R4: Each output sends cells in the order their locations entered its queue, including cells that arrived in different slots.
- R5: Cells to different outputs are sent concurrently. A permutation of four cells in slot n appears on all four outputs in slot n+1.
- R6: There are 16 shared locations. A cell arriving while none is free (or while its destination queue is full) is discarded, and the drop counter of its input port (`drop_count[i]`) increments by one.
- R7: `in_sop` is sampled only in the first cycle of a slot. A start flag raised in any other cycle produces no output cell and changes no drop counter.
- R8: A location is returned to the free pool once its cell has been fully sent. After the buffer has been filled and drained, new cells are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | output | 1 | High in the first cycle of each cell slot |
| in_sop | input | NPORT | Per input: a cell starts this slot (sampled only with `slot_start`) |
| in_dest | input | NPORT x log2(NPORT) | Per input: destination output port, sampled with `in_sop` |
| in_byte | input | NPORT x 8 | Per input: cell byte for the current slot cycle |
| out_valid | output | NPORT | Per output: a cell byte is present |
| out_sop | output | NPORT | Per output: first byte of a cell |
| out_byte | output | NPORT x 8 | Per output: cell byte |
| drop_count | output | NPORT x DROP_W | Per input: number of discarded cells, wrapping |

## Verification
Two things can happen in the same first cycle of a slot: several inputs compete for free locations and for the same output queue, while outputs return locations to the pool in the slot's last cycle. The bench drives all four inputs into output 0 for five back-to-back slots. In that run, allocation outpaces the single draining output until the pool runs dry in the fifth slot. There it expects inputs 0 to 2 to win and input 3 to be dropped, and it expects the 19 accepted cells to emerge in strict acceptance order. A final permutation then confirms that every location came back.

// File: rtl/cell_switch_pkg.sv
package cell_switch_pkg;
    localparam int DEF_PORTS      = 4;
    localparam int DEF_LOCATIONS  = 16;
    localparam int DEF_CELL_BYTES = 53;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/loc_fifo.sv
// Circular FIFO of memory locations with several push ports (served in index
// order) and a multi-entry pop given as a count, with the head entries visible.
module loc_fifo #(
    parameter int DEPTH     = 16,
    parameter int W         = 4,
    parameter int NPUSH     = 4,
    parameter int NPOP      = 1,
    parameter bit INIT_FULL = 1'b0,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPUSH-1:0]           push_vld,
    input  logic [NPUSH-1:0][W-1:0]    push_data,
    input  logic [CW-1:0]              pop_num,
    output logic [CW-1:0]              count,
    output logic [NPOP-1:0][W-1:0]     peek
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    always_comb begin
        int n;
        st_d = st_q;
        n = 0;
        for (int i = 0; i < NPUSH; i++) begin
            if (push_vld[i]) begin
                st_d.mem[PW'((int'(st_q.wr) + n) % DEPTH)] = push_data[i];
                n = n + 1;
            end
        end
        st_d.wr  = PW'((int'(st_q.wr) + n) % DEPTH);
        st_d.rd  = PW'((int'(st_q.rd) + int'(pop_num)) % DEPTH);
        st_d.cnt = CW'(int'(st_q.cnt) + n - int'(pop_num));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rd  <= '0;
            st_q.wr  <= '0;
            st_q.cnt <= INIT_FULL ? CW'(DEPTH) : '0;
            for (int k = 0; k < DEPTH; k++) st_q.mem[k] <= W'(k);
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    generate
        for (genvar j = 0; j < NPOP; j++) begin : g_peek
            assign peek[j] = st_q.mem[PW'((int'(st_q.rd) + j) % DEPTH)];
        end
    endgenerate

    // R6: pushes never exceed capacity; pops never exceed content
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) + $countones(push_vld) <= DEPTH + int'(pop_num));
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_num <= st_q.cnt);
endmodule

// File: rtl/cell_ram.sv
// Shared cell store: one byte lane per writer and per reader, common byte index.
module cell_ram #(
    parameter int NLOC       = 16,
    parameter int CELL_BYTES = 53,
    parameter int NWR        = 4,
    parameter int NRD        = 4,
    localparam int LW = $clog2(NLOC),
    localparam int IW = $clog2(CELL_BYTES)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NWR-1:0]                         wr_en,
    input  logic [NWR-1:0][LW-1:0]                 wr_loc,
    input  logic [IW-1:0]                          byte_idx,
    input  cell_switch_pkg::byte_t [NWR-1:0]       wr_byte,
    input  logic [NRD-1:0][LW-1:0]                 rd_loc,
    output cell_switch_pkg::byte_t [NRD-1:0]       rd_byte
);
    cell_switch_pkg::byte_t store [NLOC][CELL_BYTES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NWR; i++) begin
            if (wr_en[i]) store[wr_loc[i]][byte_idx] <= wr_byte[i];
        end
    end

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            assign rd_byte[r] = store[rd_loc[r]][byte_idx];
        end
        for (genvar a = 0; a < NWR; a++) begin : g_wa
            for (genvar b = a + 1; b < NWR; b++) begin : g_wb
                // R3: simultaneous writers always own distinct locations
                p_distinct_writers_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en[a] && wr_en[b]) |-> (wr_loc[a] != wr_loc[b]));
            end
        end
    endgenerate
endmodule

// File: rtl/cell_switch.sv
module cell_switch #(
    parameter int NPORT      = cell_switch_pkg::DEF_PORTS,
    parameter int NLOC       = cell_switch_pkg::DEF_LOCATIONS,
    parameter int CELL_BYTES = cell_switch_pkg::DEF_CELL_BYTES,
    parameter int QDEPTH     = cell_switch_pkg::DEF_LOCATIONS,
    parameter int DROP_W     = 8,
    localparam int DW  = $clog2(NPORT),
    localparam int LW  = $clog2(NLOC),
    localparam int IW  = $clog2(CELL_BYTES),
    localparam int FCW = $clog2(NLOC + 1),
    localparam int QCW = $clog2(QDEPTH + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    output logic                                 slot_start,
    input  logic [NPORT-1:0]                     in_sop,
    input  logic [NPORT-1:0][DW-1:0]             in_dest,
    input  cell_switch_pkg::byte_t [NPORT-1:0]   in_byte,
    output logic [NPORT-1:0]                     out_valid,
    output logic [NPORT-1:0]                     out_sop,
    output cell_switch_pkg::byte_t [NPORT-1:0]   out_byte,
    output logic [NPORT-1:0][DROP_W-1:0]         drop_count
);
    typedef struct packed {
        logic [IW-1:0]                   cnt;
        logic [NPORT-1:0]                in_busy;
        logic [NPORT-1:0][LW-1:0]        in_loc;
        logic [NPORT-1:0]                out_busy;
        logic [NPORT-1:0][LW-1:0]        out_loc;
        logic [NPORT-1:0][DROP_W-1:0]    drop;
    } sw_st_t;

    sw_st_t st_q, st_d;

    logic                              first, last;
    logic [FCW-1:0]                    free_cnt, free_pop_num;
    logic [NPORT-1:0][LW-1:0]          free_peek;
    logic [NPORT-1:0]                  free_push_vld;
    logic [NPORT-1:0][NPORT-1:0]       oq_push_vld;
    logic [NPORT-1:0][LW-1:0]          alloc;
    logic [NPORT-1:0][QCW-1:0]         oq_pop_num, oq_cnt;
    logic [NPORT-1:0][0:0][LW-1:0]     oq_peek;
    logic [NPORT-1:0]                  wr_en;
    logic [NPORT-1:0][LW-1:0]          wr_loc;

    assign first = (st_q.cnt == '0);
    assign last  = (st_q.cnt == IW'(CELL_BYTES - 1));

    always_comb begin
        int used;
        int d;
        int qadd [NPORT];
        st_d          = st_q;
        used          = 0;
        d             = 0;
        alloc         = '0;
        oq_push_vld   = '0;
        oq_pop_num    = '0;
        free_push_vld = '0;
        wr_en         = '0;
        wr_loc        = '0;
        for (int o = 0; o < NPORT; o++) qadd[o] = 0;

        st_d.cnt = last ? '0 : st_q.cnt + IW'(1);

        // Admission: fixed order, lowest input index first
        if (first) begin
            for (int i = 0; i < NPORT; i++) begin
                if (in_sop[i]) begin
                    d = int'(in_dest[i]);
                    if (used < int'(free_cnt) && int'(oq_cnt[d]) + qadd[d] < QDEPTH) begin
                        alloc[i]          = free_peek[used];
                        oq_push_vld[d][i] = 1'b1;
                        used              = used + 1;
                        qadd[d]           = qadd[d] + 1;
                        st_d.in_busy[i]   = 1'b1;
                        st_d.in_loc[i]    = free_peek[used - 1];
                        wr_en[i]          = 1'b1;
                        wr_loc[i]         = free_peek[used - 1];
                    end else begin
                        st_d.drop[i] = st_q.drop[i] + DROP_W'(1);
                    end
                end
            end
        end else begin
            wr_en  = st_q.in_busy;
            wr_loc = st_q.in_loc;
        end
        free_pop_num = FCW'(used);

        // Slot end: retire finished cells, start the next ones
        if (last) begin
            st_d.in_busy = '0;
            for (int o = 0; o < NPORT; o++) begin
                free_push_vld[o] = st_q.out_busy[o];
                if (oq_cnt[o] != '0) begin
                    oq_pop_num[o]    = QCW'(1);
                    st_d.out_busy[o] = 1'b1;
                    st_d.out_loc[o]  = oq_peek[o][0];
                end else begin
                    st_d.out_busy[o] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    loc_fifo #(.DEPTH(NLOC), .W(LW), .NPUSH(NPORT), .NPOP(NPORT), .INIT_FULL(1'b1)) u_free (
        .clk(clk), .rst_n(rst_n), .push_vld(free_push_vld), .push_data(st_q.out_loc),
        .pop_num(free_pop_num), .count(free_cnt), .peek(free_peek)
    );

    generate
        for (genvar o = 0; o < NPORT; o++) begin : g_oq
            loc_fifo #(.DEPTH(QDEPTH), .W(LW), .NPUSH(NPORT), .NPOP(1), .INIT_FULL(1'b0)) u_q (
                .clk(clk), .rst_n(rst_n), .push_vld(oq_push_vld[o]), .push_data(alloc),
                .pop_num(oq_pop_num[o]), .count(oq_cnt[o]), .peek(oq_peek[o])
            );
        end
    endgenerate

    cell_ram #(.NLOC(NLOC), .CELL_BYTES(CELL_BYTES), .NWR(NPORT), .NRD(NPORT)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(wr_loc), .byte_idx(st_q.cnt),
        .wr_byte(in_byte), .rd_loc(st_q.out_loc), .rd_byte(out_byte)
    );

    assign slot_start = first;
    assign out_valid  = st_q.out_busy;
    assign out_sop    = st_q.out_busy & {NPORT{first}};
    assign drop_count = st_q.drop;

    // ---------------- assertions ----------------
    int q_total;
    always_comb begin
        q_total = 0;
        for (int o = 0; o < NPORT; o++) q_total = q_total + int'(oq_cnt[o]);
    end

    // R8: every location is in exactly one of: free pool, a queue, an active output
    p_loc_conserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) + q_total + $countones(st_q.out_busy) == NLOC);

    // R2: an output's busy state only changes at a slot boundary
    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(st_q.out_busy));

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_chk
            // R6: drop counters only move as a result of first-cycle admission
            p_drop_at_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !first |=> $stable(st_q.drop[i]));
            // R7: a cell reception never begins outside the first slot cycle
            p_start_at_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !first |=> !$rose(st_q.in_busy[i]));
        end
    endgenerate
endmodule

// File: tb/tb_cell_switch.sv
`timescale 1ns/1ps
module tb_cell_switch;
    localparam int NP = 4;
    localparam int CB = 53;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_start;
    logic [NP-1:0] in_sop = '0;
    logic [NP-1:0][1:0] in_dest = '0;
    logic [NP-1:0][7:0] in_byte = '0;
    logic [NP-1:0] out_valid, out_sop;
    logic [NP-1:0][7:0] out_byte;
    logic [NP-1:0][7:0] drop_count;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int slot_no = 0;

    logic [7:0] rx_tag [NP][32];
    int rx_slot [NP][32];
    int rx_n [NP];
    int rx_idx [NP];
    logic [7:0] rx_cur [NP];

    always #2.5 clk = ~clk;

    cell_switch dut (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .in_sop(in_sop),
        .in_dest(in_dest), .in_byte(in_byte), .out_valid(out_valid),
        .out_sop(out_sop), .out_byte(out_byte), .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && slot_start) slot_no <= slot_no + 1;
    end

    // Output monitor: collects each cell, checks byte sequence tag+k (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_sop[o]) begin
                    rx_cur[o] = out_byte[o];
                    rx_idx[o] = 1;
                    if (rx_n[o] < 32) begin
                        rx_tag[o][rx_n[o]] = out_byte[o];
                        rx_slot[o][rx_n[o]] = slot_no;
                    end
                    rx_n[o]++;
                end else if (out_valid[o]) begin
                    if (out_byte[o] !== 8'(rx_cur[o] + 8'(rx_idx[o]))) begin
                        n_checks++;
                        n_fail++;
                        $display("FAIL R2 out%0d byte%0d actual=%0d expected=%0d",
                                 o, rx_idx[o], out_byte[o], 8'(rx_cur[o] + 8'(rx_idx[o])));
                    end
                    rx_idx[o]++;
                end else if (rx_idx[o] != 0) begin
                    check(rx_idx[o] == CB, "R2 cell length", rx_idx[o], CB);
                    rx_idx[o] = 0;
                end
            end
        end
    end

    task automatic clear_rx();
        for (int o = 0; o < NP; o++) rx_n[o] = 0;
    endtask

    // Drive one slot; returns the slot number in which cells were offered
    task automatic send_slot(input logic [3:0] mask, input logic [3:0][1:0] dest,
                             input logic [3:0][7:0] tag, output int s);
        while (!slot_start) @(negedge clk);
        s = slot_no;
        in_sop = mask;
        in_dest = dest;
        for (int i = 0; i < NP; i++) in_byte[i] = tag[i];
        for (int k = 1; k < CB; k++) begin
            @(negedge clk);
            in_sop = '0;
            for (int i = 0; i < NP; i++) in_byte[i] = 8'(tag[i] + 8'(k));
        end
        @(negedge clk);
        in_sop = '0;
    endtask

    task automatic idle_slots(input int n);
        int s;
        for (int j = 0; j < n; j++) send_slot(4'b0, '0, '0, s);
    endtask

    task automatic expect_rx(input int o, input int n, input int tag, input int sl, input string req);
        check(rx_n[o] > n, {req, " cell present"}, rx_n[o], n + 1);
        if (rx_n[o] > n) begin
            check(rx_tag[o][n] == 8'(tag), {req, " tag"}, rx_tag[o][n], tag);
            if (sl >= 0) check(rx_slot[o][n] == sl, {req, " slot"}, rx_slot[o][n], sl);
        end
    endtask

    task automatic t_reset();
        int gap;
        check(slot_start == 1'b1, "R1 slot_start after reset", slot_start, 1);
        check(out_valid == '0, "R1 out_valid idle", out_valid, 0);
        check(drop_count == '0, "R1 drop counters zero", drop_count, 0);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!slot_start);
        check(gap == CB, "R1 slot period", gap, CB);
    endtask

    task automatic t_single();
        int s;
        clear_rx();
        send_slot(4'b0001, {2'd0, 2'd0, 2'd0, 2'd2}, {8'h0, 8'h0, 8'h0, 8'h10}, s);
        idle_slots(2);
        expect_rx(2, 0, 8'h10, s + 1, "R2");
        check(rx_n[2] == 1, "R2 exactly one cell", rx_n[2], 1);
    endtask

    task automatic t_permutation();
        int s;
        clear_rx();
        send_slot(4'b1111, {2'd0, 2'd1, 2'd2, 2'd3}, {8'h33, 8'h32, 8'h31, 8'h30}, s);
        idle_slots(2);
        for (int i = 0; i < NP; i++) expect_rx(3 - i, 0, 8'h30 + i, s + 1, "R5");
    endtask

    task automatic t_same_output();
        int s;
        clear_rx();
        send_slot(4'b1111, {2'd1, 2'd1, 2'd1, 2'd1}, {8'h43, 8'h42, 8'h41, 8'h40}, s);
        idle_slots(5);
        for (int i = 0; i < NP; i++) expect_rx(1, i, 8'h40 + i, s + 1 + i, "R3");
    endtask

    task automatic t_order_across_slots();
        int s0, s1;
        clear_rx();
        send_slot(4'b0110, {2'd0, 2'd3, 2'd3, 2'd0}, {8'h0, 8'h52, 8'h51, 8'h0}, s0);
        send_slot(4'b0001, {2'd0, 2'd0, 2'd0, 2'd3}, {8'h0, 8'h0, 8'h0, 8'h50}, s1);
        idle_slots(4);
        expect_rx(3, 0, 8'h51, s0 + 1, "R4");
        expect_rx(3, 1, 8'h52, s0 + 2, "R4");
        expect_rx(3, 2, 8'h50, s0 + 3, "R4");
    endtask

    task automatic t_ignored_sop();
        logic [NP-1:0][7:0] drops_before;
        clear_rx();
        drops_before = drop_count;
        while (!slot_start) @(negedge clk);
        repeat (5) @(negedge clk);
        in_sop = 4'b0010;
        in_dest = {2'd0, 2'd0, 2'd1, 2'd0};
        @(negedge clk);
        in_sop = '0;
        idle_slots(3);
        check(rx_n[0] + rx_n[1] + rx_n[2] + rx_n[3] == 0, "R7 no cell emitted",
              rx_n[0] + rx_n[1] + rx_n[2] + rx_n[3], 0);
        check(drop_count == drops_before, "R7 drop counters unchanged", drop_count, drops_before);
    endtask

    task automatic t_fill_and_drain();
        int s;
        logic [3:0][7:0] tags;
        int n;
        clear_rx();
        for (int sl = 0; sl < 5; sl++) begin
            for (int i = 0; i < NP; i++) tags[i] = 8'(8'h80 + sl * 4 + i);
            send_slot(4'b1111, '0, tags, s);
        end
        check(drop_count[0] == 0, "R6 drop in0", drop_count[0], 0);
        check(drop_count[1] == 0, "R6 drop in1", drop_count[1], 0);
        check(drop_count[2] == 0, "R6 drop in2", drop_count[2], 0);
        check(drop_count[3] == 1, "R6 drop in3", drop_count[3], 1);
        idle_slots(17);
        check(rx_n[0] == 19, "R6 accepted cell count", rx_n[0], 19);
        n = 0;
        for (int sl = 0; sl < 5; sl++) begin
            for (int i = 0; i < NP; i++) begin
                if (!(sl == 4 && i == 3)) begin
                    if (n < 32 && rx_n[0] > n)
                        check(rx_tag[0][n] == 8'(8'h80 + sl * 4 + i), "R4 acceptance order",
                              rx_tag[0][n], 8'(8'h80 + sl * 4 + i));
                    n++;
                end
            end
        end
        // R8: all locations recycled, a full permutation is accepted again
        clear_rx();
        send_slot(4'b1111, {2'd2, 2'd3, 2'd0, 2'd1}, {8'hA3, 8'hA2, 8'hA1, 8'hA0}, s);
        idle_slots(2);
        expect_rx(1, 0, 8'hA0, s + 1, "R8");
        expect_rx(0, 0, 8'hA1, s + 1, "R8");
        expect_rx(3, 0, 8'hA2, s + 1, "R8");
        expect_rx(2, 0, 8'hA3, s + 1, "R8");
        check(drop_count[3] == 1, "R8 no new drops", drop_count[3], 1);
    endtask

    initial begin
        for (int o = 0; o < NP; o++) begin
            rx_n[o] = 0;
            rx_idx[o] = 0;
            rx_cur[o] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_permutation();
        t_same_output();
        t_order_across_slots();
        t_ignored_sop();
        t_fill_and_drain();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
        $finish;
    end
endmodule